// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port behind a byte-wide register interface. Each pin has a direction bit. The pin data is reached through an address window: address bits [9:2] act as a per-pin mask. Software can therefore set or read any subset of pins in one access, with no read-modify-write. The port drives pin values and output enables. It samples the pins through a two-flop synchronizer, and the synchronized levels also go out to a separate interrupt detector.

The interrupt configuration registers (sense, both-edges, event, enable) are stored here and drive the detector. The detector's raw and masked status come back in as inputs so they can be read. A write to the clear offset is passed on as a one-cycle pulse carrying the written bits.

Each access is run by a small state machine with three states: `ST_IDLE`, `ST_WRITE` and `ST_READ`.
- `ST_IDLE` waits for `req`. With `we` high it goes to `ST_WRITE`; with `we` low it goes to `ST_READ`.
- `ST_WRITE` and `ST_READ` last one cycle each, raise `ack`, and always return to `ST_IDLE`.
- A write takes effect at the clock edge that ends `ST_WRITE`.
- Read data is valid while `ack` is high in `ST_READ`.
- `req` is only looked at in `ST_IDLE`.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, the direction, output data and the four interrupt configuration registers are all zero, so `pin_oe` and `pin_out` are 0x00, and `ack` is low.
- R2: A request taken in `ST_IDLE` gives `ack` high for exactly one cycle, in the cycle that follows, and never for two cycles in a row.
- R3: A write to an offset below 0x400 changes output bit n only if address bit n+2 is 1 and direction bit n is 1. Pin n alone sits at offset 1<<(n+2), and 0x3FC selects all pins.
- R4: Write data aimed at an input pin is discarded. When that pin later becomes an output, it still drives its earlier value.
- R5: A read below 0x400 returns, for each bit selected by address bits [9:2], the driven value if the pin is an output or the synchronized level if it is an input. Unselected bits read as zero.
- R6: The direction register is at 0x400 and is readable. A 1 makes the pin an output, and `pin_oe` follows it.
- R7: The sense (0x404), both-edges (0x408), event (0x40C) and enable (0x410) registers are writable, readable back, and drive `irq_sense`, `irq_both`, `irq_event` and `irq_enable`.
- R8: Reads of 0x414 return `irq_raw` and reads of 0x418 return `irq_masked`. Writes to these two offsets change nothing.
- R9: A write to 0x41C raises `irq_clr_pulse` for one cycle, during the `ack` cycle, with `irq_clr_bits` equal to the written byte. No stored register changes, and a read of 0x41C returns zero.
- R10: Any other offset (misaligned, or from 0x420 upward) reads as zero, and a write to it changes nothing.
- R11: `pin_sync` equals `pin_in` as sampled two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled in idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 8 | Write data |
| ack | output | 1 | Access completes this cycle |
| rdata | output | 8 | Read data, valid with ack on a read |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Driven pin values |
| pin_oe | output | 8 | Pin output enables |
| pin_sync | output | 8 | Synchronized pin levels for the detector |
| irq_sense | output | 8 | Level/edge select per pin |
| irq_both | output | 8 | Both-edges select per pin |
| irq_event | output | 8 | Polarity/edge select per pin |
| irq_enable | output | 8 | Interrupt enable per pin |
| irq_raw | input | 8 | Raw status from the detector |
| irq_masked | input | 8 | Masked status from the detector |
| irq_clr_pulse | output | 1 | One-cycle clear strobe |
| irq_clr_bits | output | 8 | Bits to clear, valid with the strobe |

## Verification
Two things can land in the same cycle:
- a change on `pin_in` moving through the synchronizer, and
- a data-window read that returns the synchronized level.

A read issued one cycle after a pin change must still return the old level. A read issued after the two-cycle lag must return the new one. The bench provokes this by changing pins with a directed check of the lag, then mixes random pin changes with random reads. Every read is judged against a model that tracks the synchronized level.

A masked write to a pin whose direction is changing is covered the same way. The direction write and the data write are issued as back-to-back operations, and `pin_out` is compared with the model after each one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bus_state_t;

    // Register slot index within the configuration block, word-spaced
    localparam int IDX_DIR    = 0;
    localparam int IDX_SENSE  = 1;
    localparam int IDX_BOTH   = 2;
    localparam int IDX_EVENT  = 3;
    localparam int IDX_ENABLE = 4;
    localparam int IDX_RAW    = 5;
    localparam int IDX_MASKED = 6;
    localparam int IDX_CLEAR  = 7;

    localparam int CFG_REGS   = 4;   // sense, both, event, enable
    localparam int CFG_SLOTS  = 8;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stable_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= async_in[i];
                stable_q <= meta_q;
            end
        end
        assign sync_out[i] = stable_q;
    end

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic              acc_wr,
    output logic              acc_rd,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata
);

    bus_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = we ? ST_WRITE : ST_READ;
            ST_WRITE: state_d = ST_IDLE;
            ST_READ:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_addr  <= '0;
            acc_wdata <= '0;
        end else if (state_q == ST_IDLE && req) begin
            acc_addr  <= addr;
            acc_wdata <= wdata;
        end
    end

    always_comb begin
        ack    = 1'b0;
        acc_wr = 1'b0;
        acc_rd = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: begin ack = 1'b1; acc_wr = 1'b1; end
            ST_READ:  begin ack = 1'b1; acc_rd = 1'b1; end
            default:  ;
        endcase
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [N_PINS-1:0] acc_wdata,
    input  logic [N_PINS-1:0] pin_sync,
    input  logic [N_PINS-1:0] irq_raw,
    input  logic [N_PINS-1:0] irq_masked,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] dout_q,
    output logic [N_PINS-1:0] sense_q,
    output logic [N_PINS-1:0] both_q,
    output logic [N_PINS-1:0] event_q,
    output logic [N_PINS-1:0] enable_q,
    output logic [N_PINS-1:0] rdata,
    output logic              clr_pulse,
    output logic [N_PINS-1:0] clr_bits
);

    localparam int                MASK_LSB   = 2;
    localparam int                MASK_MSB   = N_PINS + 1;
    localparam logic [ADDR_W-1:0] CFG_BASE   = ADDR_W'(1) << (N_PINS + 2);
    localparam logic [ADDR_W-1:0] CFG_SPAN   = ADDR_W'(4 * CFG_SLOTS);

    logic              in_window;
    logic [N_PINS-1:0] pin_mask;
    logic [ADDR_W-1:0] cfg_off;
    logic              cfg_hit;
    logic [2:0]        cfg_idx;
    logic [N_PINS-1:0] wr_sel;
    logic [N_PINS-1:0] level;
    logic [N_PINS-1:0] cfg_q [CFG_REGS];

    // Address decode
    assign in_window = (acc_addr < CFG_BASE);
    assign pin_mask  = acc_addr[MASK_MSB:MASK_LSB];
    assign cfg_off   = acc_addr - CFG_BASE;
    assign cfg_hit   = !in_window && (cfg_off < CFG_SPAN) && (cfg_off[1:0] == 2'b00);
    assign cfg_idx   = cfg_off[4:2];

    // Output data: only masked pins that are outputs take the write
    assign wr_sel = pin_mask & dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (acc_wr && in_window) begin
            dout_q <= (dout_q & ~wr_sel) | (acc_wdata & wr_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (acc_wr && cfg_hit && cfg_idx == 3'(IDX_DIR)) begin
            dir_q <= acc_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < CFG_REGS; k++) cfg_q[k] <= '0;
        end else if (acc_wr && cfg_hit) begin
            for (int k = 0; k < CFG_REGS; k++) begin
                if (cfg_idx == 3'(IDX_SENSE + k)) cfg_q[k] <= acc_wdata;
            end
        end
    end

    assign sense_q  = cfg_q[0];
    assign both_q   = cfg_q[1];
    assign event_q  = cfg_q[2];
    assign enable_q = cfg_q[3];

    // Clear is forwarded, never stored
    assign clr_pulse = acc_wr && cfg_hit && (cfg_idx == 3'(IDX_CLEAR));
    assign clr_bits  = clr_pulse ? acc_wdata : '0;

    // Read path
    assign level = (dir_q & dout_q) | (~dir_q & pin_sync);

    always_comb begin
        rdata = '0;
        if (acc_rd) begin
            if (in_window) begin
                rdata = level & pin_mask;
            end else if (cfg_hit) begin
                unique case (cfg_idx)
                    3'(IDX_DIR):    rdata = dir_q;
                    3'(IDX_SENSE):  rdata = sense_q;
                    3'(IDX_BOTH):   rdata = both_q;
                    3'(IDX_EVENT):  rdata = event_q;
                    3'(IDX_ENABLE): rdata = enable_q;
                    3'(IDX_RAW):    rdata = irq_raw;
                    3'(IDX_MASKED): rdata = irq_masked;
                    3'(IDX_CLEAR):  rdata = '0;
                    default:        rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wdata,
    output logic              ack,
    output logic [N_PINS-1:0] rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_sync,
    output logic [N_PINS-1:0] irq_sense,
    output logic [N_PINS-1:0] irq_both,
    output logic [N_PINS-1:0] irq_event,
    output logic [N_PINS-1:0] irq_enable,
    input  logic [N_PINS-1:0] irq_raw,
    input  logic [N_PINS-1:0] irq_masked,
    output logic              irq_clr_pulse,
    output logic [N_PINS-1:0] irq_clr_bits
);

    logic              acc_wr;
    logic              acc_rd;
    logic [ADDR_W-1:0] acc_addr;
    logic [N_PINS-1:0] acc_wdata;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] dout_q;

    gpio_sync #(.WIDTH(N_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(N_PINS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .ack       (ack),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata)
    );

    gpio_regfile #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_wr     (acc_wr),
        .acc_rd     (acc_rd),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .pin_sync   (pin_sync),
        .irq_raw    (irq_raw),
        .irq_masked (irq_masked),
        .dir_q      (dir_q),
        .dout_q     (dout_q),
        .sense_q    (irq_sense),
        .both_q     (irq_both),
        .event_q    (irq_event),
        .enable_q   (irq_enable),
        .rdata      (rdata),
        .clr_pulse  (irq_clr_pulse),
        .clr_bits   (irq_clr_bits)
    );

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ack,
    input logic [N_PINS-1:0] pin_in,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic [N_PINS-1:0] pin_sync,
    input logic [N_PINS-1:0] irq_sense,
    input logic [N_PINS-1:0] irq_both,
    input logic [N_PINS-1:0] irq_event,
    input logic [N_PINS-1:0] irq_enable,
    input logic              irq_clr_pulse
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R2
    AST_ACK_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req)); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack) |-> $stable(pin_out)); // R3
    AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack) |-> $stable(pin_oe)); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack) |-> $stable({irq_sense, irq_both, irq_event, irq_enable})); // R7
    AST_CLR_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_pulse |-> ack); // R9
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_pulse |=> !irq_clr_pulse); // R9
    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (pin_sync == $past(pin_in, 2))); // R11

endmodule

bind gpio_masked_port gpio_masked_port_chk #(.N_PINS(N_PINS)) u_chk (.*);

// File: tb/tb_gpio_masked_port.sv
module tb_gpio_masked_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe, pin_sync;
    logic [7:0]  irq_sense, irq_both, irq_event, irq_enable;
    logic [7:0]  irq_raw = '0;
    logic [7:0]  irq_masked = '0;
    logic        irq_clr_pulse;
    logic [7:0]  irq_clr_bits;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model
    logic [7:0] m_dir = '0, m_dout = '0, m_pins = '0;
    logic [7:0] m_sense = '0, m_both = '0, m_event = '0, m_enable = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_masked_port dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_sync(pin_sync), .irq_sense(irq_sense), .irq_both(irq_both),
        .irq_event(irq_event), .irq_enable(irq_enable), .irq_raw(irq_raw),
        .irq_masked(irq_masked), .irq_clr_pulse(irq_clr_pulse), .irq_clr_bits(irq_clr_bits)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [11:0] a);
        if (a < 12'h400) return a[9:2] & ((m_dir & m_dout) | (~m_dir & m_pins));
        case (a)
            12'h400: return m_dir;
            12'h404: return m_sense;
            12'h408: return m_both;
            12'h40C: return m_event;
            12'h410: return m_enable;
            12'h414: return irq_raw;
            12'h418: return irq_masked;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [7:0] d);
        if (a < 12'h400) begin
            m_dout = (m_dout & ~(a[9:2] & m_dir)) | (d & a[9:2] & m_dir);
        end else begin
            case (a)
                12'h400: m_dir    = d;
                12'h404: m_sense  = d;
                12'h408: m_both   = d;
                12'h40C: m_event  = d;
                12'h410: m_enable = d;
                default: ;
            endcase
        end
    endfunction

    task automatic do_op(input logic w, input logic [11:0] a, input logic [7:0] d);
        logic [7:0] rd;
        logic       got_ack, clrp;
        logic [7:0] clrb;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        got_ack = ack; rd = rdata; clrp = irq_clr_pulse; clrb = irq_clr_bits;
        @(negedge clk);
        check("R2 ack in cycle after request", 32'(got_ack), 32'd1);
        check("R2 ack lasts one cycle", 32'(ack), 32'd0);
        if (w) begin
            model_write(a, d);
            check("R9 clear pulse", 32'(clrp), 32'(a == 12'h41C));
            check("R9 clear bits", 32'(clrb), (a == 12'h41C) ? 32'(d) : 32'd0);
        end else begin
            if (a < 12'h400)      check("R5 data window read", 32'(rd), 32'(exp_read(a)));
            else if (a > 12'h41C || a[1:0] != 2'b00) check("R10 unmapped read", 32'(rd), 32'(exp_read(a)));
            else if (a >= 12'h414) check("R8 R9 status read", 32'(rd), 32'(exp_read(a)));
            else                  check("R6 R7 register readback", 32'(rd), 32'(exp_read(a)));
        end
        check("R3 R4 pin_out vs model", 32'(pin_out), 32'(m_dout));
        check("R6 pin_oe follows direction", 32'(pin_oe), 32'(m_dir));
        check("R7 sense out", 32'(irq_sense), 32'(m_sense));
        check("R7 both out", 32'(irq_both), 32'(m_both));
        check("R7 event out", 32'(irq_event), 32'(m_event));
        check("R7 enable out", 32'(irq_enable), 32'(m_enable));
    endtask

    task automatic set_pins(input logic [7:0] v);
        pin_in = v;
        m_pins = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] old_sync;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe after reset", 32'(pin_oe), 32'd0);
        check("R1 pin_out after reset", 32'(pin_out), 32'd0);
        check("R1 cfg outputs after reset", 32'({irq_sense, irq_both, irq_event, irq_enable}), 32'd0);
        check("R1 ack low after reset", 32'(ack), 32'd0);
        do_op(1'b0, 12'h400, 8'h00);

        // R4 no preload on inputs
        do_op(1'b1, 12'h3FC, 8'hFF);
        check("R4 input pin ignores write", 32'(pin_out), 32'd0);
        do_op(1'b1, 12'h400, 8'hFF);
        check("R4 no preloaded value after turning output", 32'(pin_out), 32'd0);

        // R3 single-pin mask: pin 3 at 1<<5
        do_op(1'b1, 12'h020, 8'hFF);
        check("R3 only pin 3 written", 32'(pin_out), 32'h08);
        do_op(1'b1, 12'h400, 8'h0F);
        do_op(1'b1, 12'h3FC, 8'hFF);
        check("R3 only output pins written", 32'(pin_out), 32'h0F);

        // R5 mixed read
        set_pins(8'hA5);
        do_op(1'b0, 12'h3FC, 8'h00);
        do_op(1'b0, 12'h0C0, 8'h00);
        do_op(1'b0, 12'h004, 8'h00);

        // R7 config regs
        do_op(1'b1, 12'h404, 8'h5A);
        do_op(1'b1, 12'h408, 8'hC3);
        do_op(1'b1, 12'h40C, 8'h81);
        do_op(1'b1, 12'h410, 8'h7E);
        do_op(1'b0, 12'h404, 8'h00);
        do_op(1'b0, 12'h410, 8'h00);

        // R8 status inputs, writes ignored
        irq_raw = 8'h3C; irq_masked = 8'h18;
        do_op(1'b1, 12'h414, 8'hFF);
        do_op(1'b1, 12'h418, 8'hFF);
        do_op(1'b0, 12'h414, 8'h00);
        do_op(1'b0, 12'h418, 8'h00);

        // R9 clear
        do_op(1'b1, 12'h41C, 8'h81);
        do_op(1'b0, 12'h41C, 8'h00);

        // R10 unmapped
        do_op(1'b1, 12'h420, 8'hFF);
        do_op(1'b1, 12'h402, 8'hFF);
        do_op(1'b1, 12'hFFC, 8'hFF);
        do_op(1'b0, 12'h420, 8'h00);
        do_op(1'b0, 12'h401, 8'h00);
        do_op(1'b0, 12'h400, 8'h00);

        // R11 synchronizer lag
        old_sync = pin_sync;
        pin_in = 8'h3C;
        @(negedge clk);
        check("R11 sync unchanged after one edge", 32'(pin_sync), 32'(old_sync));
        @(negedge clk);
        check("R11 sync updated after two edges", 32'(pin_sync), 32'h3C);
        m_pins = 8'h3C;

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            int unsigned kind;
            kind = $urandom_range(0, 9);
            if (kind < 5)      a = {2'b00, 8'($urandom), 2'b00};
            else if (kind < 8) a = 12'h400 + 12'(4 * $urandom_range(0, 7));
            else               a = 12'h420 + 12'($urandom_range(0, 3000));
            if ($urandom_range(0, 7) == 0) set_pins(8'($urandom));
            if ($urandom_range(0, 7) == 0) begin
                irq_raw = 8'($urandom);
                irq_masked = 8'($urandom);
            end
            do_op(1'($urandom), a, 8'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule